// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses the source of a protected memory supply rail: the main supply or a backup battery. It also drives an active-low power-fail warning. Its inputs are single-bit flags from analog comparators. They report that the main supply is under the switch threshold, under the higher reset threshold, or under an absolute floor, that the battery sits above the main supply, and that the power-fail sense input is under its reference. Each flag is resynchronised to the block clock. A flag must then hold a new value for a set number of clocks before the mode state machine or the warning output responds to it.

Entry to battery mode and exit from it use different conditions. The rail moves to the battery when the main supply is under the switch threshold and the battery is above it. It also moves to the battery whenever the main supply is under the floor, whatever the battery level. It returns to the main supply only once the main supply is back above the reset threshold, and the battery level plays no part in that decision. A battery that is charged above the main supply therefore never pulls the rail away from a healthy main supply, and the battery can be removed without risk while the main supply stays above the switch threshold.

Top module: `swo_supply_switch`

## Requirements
- R1: While rst_n is low (sampled on the clock), rail_batt_o is 0 (main supply), batt_mode_o is 0 and pf_n_o is 0. After reset the block starts in main-supply mode with all qualified flags taken as deasserted.
- R2: In main-supply mode, if main_below_sw_i and batt_above_main_i are both qualified high, the block enters battery mode: rail_batt_o = 1 and batt_mode_o = 1.
- R3: In main-supply mode, if main_below_floor_i is qualified high, the block enters battery mode whatever the value of batt_above_main_i.
- R4: In main-supply mode, if main_below_sw_i is high while batt_above_main_i and main_below_floor_i are low, the rail stays on the main supply.
- R5: In main-supply mode, if main_below_sw_i and main_below_floor_i are low, batt_above_main_i has no effect and the rail stays on the main supply. This covers battery removal and a battery above the main supply.
- R6: In battery mode, the block returns to the main supply only when main_below_rst_i, main_below_sw_i and main_below_floor_i are all qualified low. batt_above_main_i has no effect on the return. Any other flag combination keeps the block in battery mode.
- R7: In main-supply mode, pf_n_o is 0 when pfin_below_ref_i or main_below_sw_i is qualified high, and 1 when both are low.
- R8: In battery mode, pf_n_o is forced to 0 whatever pfin_below_ref_i is.
- R9: A flag change reaches the state machine only after the synchronised flag has held its new value for STABLE_CYCLES consecutive clocks. A pulse that lasts STABLE_CYCLES-1 clocks is ignored. A pulse that lasts STABLE_CYCLES clocks is acted on.
- R10: A sustained flag change that is applied before rising edge 1 changes batt_mode_o on rising edge SYNC_STAGES+STABLE_CYCLES+1 and not on any earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_below_sw_i | input | 1 | Main supply is under the switch threshold (asynchronous) |
| main_below_rst_i | input | 1 | Main supply is under the reset threshold (asynchronous) |
| batt_above_main_i | input | 1 | Battery voltage is above the main supply (asynchronous) |
| main_below_floor_i | input | 1 | Main supply is under the absolute floor (asynchronous) |
| pfin_below_ref_i | input | 1 | Power-fail sense input is under its reference (asynchronous) |
| rail_batt_o | output | 1 | Supply switch select: 1 = battery, 0 = main supply |
| batt_mode_o | output | 1 | Battery-mode status |
| pf_n_o | output | 1 | Power-fail warning, active low |

## Verification
The bench builds the block with SYNC_STAGES = 2 and STABLE_CYCLES = 4. With these values a pulse one clock shorter than the qualification window, and the exact edge at which a change takes effect, can be checked in a few cycles. These short windows also let the bench sweep all 32 flag combinations, starting from both main-supply and battery mode, and compare the settled select, status and warning outputs against entry and exit rules computed in the bench.

// File: rtl/swo_pkg.sv
// Shared definitions for the supply switchover controller.
// Assumes: flag indices are used only inside this block.
package swo_pkg;
    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_BATT = 1'b1
    } src_e;

    localparam int NFLAG    = 5;
    localparam int FL_SW    = 0;
    localparam int FL_RST   = 1;
    localparam int FL_BA    = 2;
    localparam int FL_FLOOR = 3;
    localparam int FL_PF    = 4;
endpackage

// File: rtl/swo_flag_qual.sv
// Resynchronises one asynchronous comparator flag. Its output then
// follows the flag only after the synchronised value has differed from
// the current output for STABLE_CYCLES consecutive clocks.
// Assumes: SYNC_STAGES >= 1, STABLE_CYCLES >= 1, synchronous active-low reset.
module swo_flag_qual #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic qual_o
);
    localparam int CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   sync_w;
    logic [CW-1:0]          cnt_q;

    // Synchroniser chain: variant chosen by stage count
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= raw_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign sync_w = chain_q[SYNC_STAGES-1];

    // Stability filter: count clocks of disagreement, update on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_o <= 1'b0;
        end else if (sync_w == qual_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            qual_o <= sync_w;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the output only moves toward the value the synchroniser showed
    assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(qual_o) |-> (qual_o == $past(sync_w)));

    // R9: a disagreement seen with an empty counter cannot update at once
    assert_no_early_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (STABLE_CYCLES > 1 && sync_w != qual_o && cnt_q == '0) |=> $stable(qual_o));
endmodule

// File: rtl/swo_mode_fsm.sv
// Mode state machine: picks the main supply or the battery from the
// qualified flags. It enters and leaves battery mode on separate rules.
// Assumes: inputs are already synchronised and filtered.
module swo_mode_fsm
    import swo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_below_sw_i,
    input  logic q_below_rst_i,
    input  logic q_batt_above_i,
    input  logic q_below_floor_i,
    output src_e state_o
);
    logic enter_w;
    logic leave_w;
    src_e next_w;

    // Entry and exit conditions
    always_comb begin
        enter_w = (q_below_sw_i && q_batt_above_i) || q_below_floor_i;
        leave_w = !q_below_rst_i && !q_below_sw_i && !q_below_floor_i;
        next_w  = state_o;
        case (state_o)
            SRC_MAIN: if (enter_w) next_w = SRC_BATT;
            SRC_BATT: if (leave_w) next_w = SRC_MAIN;
            default:  next_w = SRC_MAIN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= SRC_MAIN;
        else        state_o <= next_w;
    end

    // R4: below the switch threshold without a higher battery, stay on main
    assert_hold_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SRC_MAIN && q_below_sw_i && !q_batt_above_i && !q_below_floor_i)
        |=> state_o == SRC_MAIN);

    // R5: battery flag alone never causes entry
    assert_batt_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SRC_MAIN && !q_below_sw_i && !q_below_floor_i)
        |=> state_o == SRC_MAIN);

    // R3: floor forces entry
    assert_floor_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SRC_MAIN && q_below_floor_i) |=> state_o == SRC_BATT);

    // R6: no return while still below the reset threshold
    assert_hold_batt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SRC_BATT && q_below_rst_i) |=> state_o == SRC_BATT);
endmodule

// File: rtl/swo_pfo_gen.sv
// Power-fail warning generator: drives the active-low output low on a
// low sense input, a main supply under the switch threshold, or battery mode.
// Assumes: inputs are qualified flags and the registered mode.
module swo_pfo_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic q_pf_below_i,
    input  logic q_below_sw_i,
    input  logic batt_mode_i,
    output logic pf_n_o
);
    // Registered warning, held low during reset
    always_ff @(posedge clk) begin
        if (!rst_n) pf_n_o <= 1'b0;
        else        pf_n_o <= !(q_pf_below_i || q_below_sw_i || batt_mode_i);
    end

    // R8: battery mode forces the warning low on the next cycle
    assert_batt_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        batt_mode_i |=> !pf_n_o);

    // R7: a low sense input drives the warning low
    assert_sense_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_pf_below_i |=> !pf_n_o);
endmodule

// File: rtl/swo_supply_switch.sv
// Top of the backup supply switchover controller. It qualifies the five
// comparator flags, runs the mode state machine and drives the rail
// select, the battery status and the power-fail warning.
// Assumes: all flag inputs are asynchronous to clk; reset is synchronous.
module swo_supply_switch
    import swo_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_below_sw_i,
    input  logic main_below_rst_i,
    input  logic batt_above_main_i,
    input  logic main_below_floor_i,
    input  logic pfin_below_ref_i,
    output logic rail_batt_o,
    output logic batt_mode_o,
    output logic pf_n_o
);
    logic [NFLAG-1:0] raw_w;
    logic [NFLAG-1:0] q_w;
    src_e             state_w;

    // Gather raw flags into a vector by index
    always_comb begin
        raw_w           = '0;
        raw_w[FL_SW]    = main_below_sw_i;
        raw_w[FL_RST]   = main_below_rst_i;
        raw_w[FL_BA]    = batt_above_main_i;
        raw_w[FL_FLOOR] = main_below_floor_i;
        raw_w[FL_PF]    = pfin_below_ref_i;
    end

    generate
        for (genvar gi = 0; gi < NFLAG; gi++) begin : g_qual
            swo_flag_qual #(
                .SYNC_STAGES  (SYNC_STAGES),
                .STABLE_CYCLES(STABLE_CYCLES)
            ) u_qual (
                .clk   (clk),
                .rst_n (rst_n),
                .raw_i (raw_w[gi]),
                .qual_o(q_w[gi])
            );
        end
    endgenerate

    swo_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .q_below_sw_i   (q_w[FL_SW]),
        .q_below_rst_i  (q_w[FL_RST]),
        .q_batt_above_i (q_w[FL_BA]),
        .q_below_floor_i(q_w[FL_FLOOR]),
        .state_o        (state_w)
    );

    assign rail_batt_o = (state_w == SRC_BATT);
    assign batt_mode_o = (state_w == SRC_BATT);

    swo_pfo_gen u_pfo (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_pf_below_i(q_w[FL_PF]),
        .q_below_sw_i(q_w[FL_SW]),
        .batt_mode_i (batt_mode_o),
        .pf_n_o      (pf_n_o)
    );

    // R2: entry needs a main supply under the switch threshold or under the floor
    assert_entry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_mode_o) |-> $past(q_w[FL_SW] || q_w[FL_FLOOR]));

    // R1: reset leaves the block on the main supply
    assert_reset_main_R1: assert property (@(posedge clk)
        !rst_n |=> (!rail_batt_o && !pf_n_o));
endmodule

// File: tb/swo_supply_switch_bench.sv
// Bench for the switchover controller: reset, latency, filter, and a
// sweep of all flag combinations from both modes.
module swo_supply_switch_bench;
    localparam int SYNC = 2;
    localparam int STB  = 4;
    localparam int SETTLE = SYNC + STB + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_sw = 0, f_rst = 0, f_ba = 0, f_fl = 0, f_pf = 0;
    logic rail_batt, batt_mode, pf_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    swo_supply_switch #(.SYNC_STAGES(SYNC), .STABLE_CYCLES(STB)) u_swo_supply_switch (
        .clk               (clk),
        .rst_n             (rst_n),
        .main_below_sw_i   (f_sw),
        .main_below_rst_i  (f_rst),
        .batt_above_main_i (f_ba),
        .main_below_floor_i(f_fl),
        .pfin_below_ref_i  (f_pf),
        .rail_batt_o       (rail_batt),
        .batt_mode_o       (batt_mode),
        .pf_n_o            (pf_n)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // flags vector order: {pf, floor, batt_above, below_rst, below_sw}
    task automatic drive(input logic [4:0] v);
        @(negedge clk);
        {f_pf, f_fl, f_ba, f_rst, f_sw} = v;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        wait_n(3);
        check("R1 rail", rail_batt, 1'b0);
        check("R1 mode", batt_mode, 1'b0);
        check("R1 pf_n", pf_n, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        wait_n(SETTLE);
        check("R1 main after reset", batt_mode, 1'b0);
        check("R7 pf_n high idle", pf_n, 1'b1);

        // R10: exact latency of a floor assertion
        drive(5'b01000);
        for (int m = 1; m <= SYNC + STB + 1; m++) begin
            @(negedge clk);
            if (m == SYNC + STB)     check("R10 not early", batt_mode, 1'b0);
            if (m == SYNC + STB + 1) check("R10 on time", batt_mode, 1'b1);
        end
        drive(5'b00000);
        wait_n(SETTLE);
        check("R6 back to main", batt_mode, 1'b0);

        // R9: pulse one clock short is ignored
        drive(5'b01000);
        wait_n(STB - 2);
        drive(5'b00000);
        begin
            logic seen = 1'b0;
            for (int i = 0; i < SETTLE + 4; i++) begin
                @(negedge clk);
                if (batt_mode) seen = 1'b1;
            end
            check("R9 short pulse ignored", seen, 1'b0);
        end
        // R9: pulse of exactly the window is taken
        drive(5'b01000);
        wait_n(STB - 1);
        drive(5'b00000);
        begin
            logic seen = 1'b0;
            for (int i = 0; i < SETTLE + 4; i++) begin
                @(negedge clk);
                if (batt_mode) seen = 1'b1;
            end
            check("R9 full pulse taken", seen, 1'b1);
        end
        wait_n(SETTLE);

        // Sweep all combinations from both modes (R2..R8)
        for (int start = 0; start < 2; start++) begin
            for (int v = 0; v < 32; v++) begin
                logic [4:0] fv;
                logic sw, rs, ba, fl, pf, enter, leave, exp_b, exp_pf;
                fv = 5'(v);
                drive(start == 1 ? 5'b00111 : 5'b00000);
                wait_n(SETTLE);
                check(start == 1 ? "R2 start batt" : "R6 start main", batt_mode, start == 1);
                drive(fv);
                wait_n(SETTLE);
                {pf, fl, ba, rs, sw} = fv;
                enter = (sw & ba) | fl;
                leave = !rs & !sw & !fl;
                exp_b = (start == 0) ? enter : !leave;
                exp_pf = !(pf | sw | exp_b);
                if (start == 0) begin
                    if (fl)             check("R3 floor entry", batt_mode, exp_b);
                    else if (sw && ba)  check("R2 sw+batt entry", batt_mode, exp_b);
                    else if (sw)        check("R4 hold main", batt_mode, exp_b);
                    else                check("R5 batt flag ignored", batt_mode, exp_b);
                    check("R7 pf_n main", pf_n, exp_pf);
                end else begin
                    check("R6 exit rule", batt_mode, exp_b);
                    if (exp_b) check("R8 pf forced low", pf_n, exp_pf);
                    else       check("R7 pf_n after exit", pf_n, exp_pf);
                end
                check("R2 rail matches mode", rail_batt, exp_b);
            end
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule